// File: doc/BRIEF.md
# System Call Interrupt Entry Unit

This block performs the architectural state change a 64-bit core makes when a system call instruction retires. On the clock edge where the retire strobe coincides with a recognised system call, it records the return address, takes a masked image of the current machine state register (MSR) into the second save/restore register, builds a reduced MSR for the handler, and redirects the next instruction address to a fixed vector.

A return-from-interrupt input reverses the entry. It sends execution back to the saved return address and merges the saved MSR fields back into the current MSR.

The work is sequenced by a small state machine with three states:
- `ST_STEADY`: no event on the last edge.
- `ST_ENTERED`: an entry was taken on the last edge.
- `ST_RESTORED`: a return was taken on the last edge.

Every state has the same three transitions:
- `T_ENTER` goes to `ST_ENTERED` when a system call retires.
- `T_RETURN` goes to `ST_RESTORED` when only the return input is high.
- `T_IDLE` goes to `ST_STEADY` otherwise.

An output process turns the next state into an action (enter, return, hold). That action drives the register updates.

Bit numbering throughout is LSB-0 (bit 0 is the least significant).

Top module: `sysint_entry`

## Requirements
- R1: While reset is low, the outputs are: `srr0_o` = 0, `srr1_o` = 0, `msr_o` = 0, `nia_o` = 0x100.
- R2: On an entry edge (`retire_i` and `is_sc_i` both high), `srr0_o` becomes `cia_i` + 4, wrapping modulo 2^64.
- R3: On an entry edge, `srr1_o` becomes `cur_msr_i` AND 0xFFFF_03E1_FFFF_FFFF. This keeps bits 0..32, 37..41 and 48..63 and zeroes the rest.
- R4: On an entry edge, `nia_o` becomes 0x0000_0000_0000_0C00.
- R5: On an entry edge, the new `msr_o` has the following bits cleared: IR (bit 5), DR (bit 4), FE0 (bit 11), FE1 (bit 8), EE (bit 15) and RI (bit 1). Every bit other than ME, HV and S is zero, and ME (bit 12) is copied from `cur_msr_i`.
- R6: On an entry edge, HV (bit 60) is copied from `cur_msr_i` when `lev_i` is 0. It is set to 1 for any other `lev_i` value.
- R7: On an entry edge, S (bit 22) is set to 1 when `uv_en_i` is 1 and `lev_i` equals 2. Otherwise it is copied from `cur_msr_i`.
- R8: When neither an entry nor a return occurs, all four outputs hold. This includes `retire_i` high with `is_sc_i` low, and `is_sc_i` high with `retire_i` low.
- R9: On a return edge (`rfi_i` high, no entry), `nia_o` becomes `srr0_o`. `msr_o` becomes (`cur_msr_i` AND NOT 0xFFFF_03E1_FFFF_FFFF) OR (`srr1_o` AND 0xFFFF_03E1_FFFF_FFFF). `srr0_o` and `srr1_o` are unchanged.
- R10: When an entry and a return are requested on the same edge, the entry is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | Instruction retires this cycle |
| is_sc_i | input | 1 | Retiring instruction is a system call |
| lev_i | input | 7 | Level field of the system call |
| uv_en_i | input | 1 | Ultravisor-level entry enable |
| rfi_i | input | 1 | Return-from-interrupt request |
| cia_i | input | 64 | Address of the retiring instruction |
| cur_msr_i | input | 64 | Current machine state register |
| srr0_o | output | 64 | Saved return address |
| srr1_o | output | 64 | Saved MSR image |
| msr_o | output | 64 | MSR written by entry or return |
| nia_o | output | 64 | Next instruction address |

## Verification
Every result of this block is registered: SRR0, SRR1, the new MSR and the next instruction address all change on the first rising edge that samples an entry or return request, and never later. The bench drives each request on a falling edge and compares the outputs at the following falling edge. It clears the request at that same falling edge, so each stimulus covers exactly one rising edge. Hold checks compare all four outputs against the values captured just before the ignored stimulus, one edge later.

// File: rtl/sysint_pkg.sv
package sysint_pkg;

    // Phase recorded by the sequencer: what happened on the last edge.
    typedef enum logic [1:0] {
        ST_STEADY   = 2'd0,
        ST_ENTERED  = 2'd1,
        ST_RESTORED = 2'd2
    } sysint_state_e;

    // Register action for the current edge.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_ENTER  = 2'd1,
        ACT_RETURN = 2'd2
    } sysint_act_e;

endpackage

// File: rtl/sysint_fsm.sv
module sysint_fsm
    import sysint_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        retire_i,
    input  logic        is_sc_i,
    input  logic        rfi_i,
    output sysint_act_e act_o
);

    sysint_state_e state_q;
    sysint_state_e state_d;
    logic          sc_take;
    logic          rfi_take;

    assign sc_take  = retire_i & is_sc_i;
    assign rfi_take = rfi_i & ~sc_take;

    // Next-state selection: T_ENTER has priority over T_RETURN (R10).
    always_comb begin
        state_d = ST_STEADY;
        unique case (state_q)
            ST_STEADY: begin
                if (sc_take)       state_d = ST_ENTERED;
                else if (rfi_take) state_d = ST_RESTORED;
                else               state_d = ST_STEADY;
            end
            ST_ENTERED: begin
                if (sc_take)       state_d = ST_ENTERED;
                else if (rfi_take) state_d = ST_RESTORED;
                else               state_d = ST_STEADY;
            end
            ST_RESTORED: begin
                if (sc_take)       state_d = ST_ENTERED;
                else if (rfi_take) state_d = ST_RESTORED;
                else               state_d = ST_STEADY;
            end
            default:               state_d = ST_STEADY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STEADY;
        else        state_q <= state_d;
    end

    // Output process: action taken on this edge.
    always_comb begin
        unique case (state_d)
            ST_ENTERED:  act_o = ACT_ENTER;
            ST_RESTORED: act_o = ACT_RETURN;
            default:     act_o = ACT_HOLD;
        endcase
    end

    // R10: a simultaneous return request loses to the entry.
    a_r10_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && is_sc_i && rfi_i) |=> (state_q == ST_ENTERED));

    // R9: a lone return request is recorded as a return.
    a_r9_return_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_i && !(retire_i && is_sc_i)) |=> (state_q == ST_RESTORED));

    // R8: a strobe without a system call is not an entry.
    a_r8_no_false_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!(retire_i && is_sc_i) && !rfi_i) |=> (state_q == ST_STEADY));

endmodule

// File: rtl/sysint_msr_xform.sv
module sysint_msr_xform #(
    parameter int XLEN    = 64,
    parameter int LEV_W   = 7,
    parameter int IR_BIT  = 5,
    parameter int DR_BIT  = 4,
    parameter int FE0_BIT = 11,
    parameter int FE1_BIT = 8,
    parameter int EE_BIT  = 15,
    parameter int RI_BIT  = 1,
    parameter int ME_BIT  = 12,
    parameter int HV_BIT  = 60,
    parameter int S_BIT   = 22
) (
    input  logic [XLEN-1:0]  cur_msr_i,
    input  logic [LEV_W-1:0] lev_i,
    input  logic             uv_en_i,
    input  logic [XLEN-1:0]  srr1_q_i,
    input  logic [XLEN-1:0]  keep_mask_i,
    output logic [XLEN-1:0]  entry_msr_o,
    output logic [XLEN-1:0]  srr1_img_o,
    output logic [XLEN-1:0]  return_msr_o
);

    localparam logic [LEV_W-1:0] LEV_UV = LEV_W'(2);

    logic lev_zero;
    logic uv_entry;

    assign lev_zero = (lev_i == '0);
    assign uv_entry = uv_en_i && (lev_i == LEV_UV);

    // Handler MSR: only ME, HV and S may survive.
    always_comb begin
        entry_msr_o          = '0;
        entry_msr_o[ME_BIT]  = cur_msr_i[ME_BIT];
        entry_msr_o[HV_BIT]  = lev_zero ? cur_msr_i[HV_BIT] : 1'b1;
        entry_msr_o[S_BIT]   = uv_entry ? 1'b1 : cur_msr_i[S_BIT];
        entry_msr_o[IR_BIT]  = 1'b0;
        entry_msr_o[DR_BIT]  = 1'b0;
        entry_msr_o[FE0_BIT] = 1'b0;
        entry_msr_o[FE1_BIT] = 1'b0;
        entry_msr_o[EE_BIT]  = 1'b0;
        entry_msr_o[RI_BIT]  = 1'b0;
    end

    assign srr1_img_o   = cur_msr_i & keep_mask_i;
    assign return_msr_o = (cur_msr_i & ~keep_mask_i) | (srr1_q_i & keep_mask_i);

endmodule

// File: rtl/sysint_entry.sv
module sysint_entry
    import sysint_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int LEV_W     = 7,
    parameter int IR_BIT    = 5,
    parameter int DR_BIT    = 4,
    parameter int FE0_BIT   = 11,
    parameter int FE1_BIT   = 8,
    parameter int EE_BIT    = 15,
    parameter int RI_BIT    = 1,
    parameter int ME_BIT    = 12,
    parameter int HV_BIT    = 60,
    parameter int S_BIT     = 22,
    parameter int SAVE_A_HI = 32,
    parameter int SAVE_B_LO = 37,
    parameter int SAVE_B_HI = 41,
    parameter int SAVE_C_LO = 48,
    parameter logic [XLEN-1:0] VECTOR    = XLEN'('h0C00),
    parameter logic [XLEN-1:0] RESET_NIA = XLEN'('h0100),
    parameter logic [XLEN-1:0] RESET_MSR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             is_sc_i,
    input  logic [LEV_W-1:0] lev_i,
    input  logic             uv_en_i,
    input  logic             rfi_i,
    input  logic [XLEN-1:0]  cia_i,
    input  logic [XLEN-1:0]  cur_msr_i,
    output logic [XLEN-1:0]  srr0_o,
    output logic [XLEN-1:0]  srr1_o,
    output logic [XLEN-1:0]  msr_o,
    output logic [XLEN-1:0]  nia_o
);

    localparam int              INSN_BYTES = 4;
    localparam logic [XLEN-1:0] INSN_STEP  = XLEN'(INSN_BYTES);

    sysint_act_e     act;
    logic [XLEN-1:0] keep_mask;
    logic [XLEN-1:0] entry_msr;
    logic [XLEN-1:0] srr1_img;
    logic [XLEN-1:0] return_msr;

    // Saved-field mask, one bit per MSR position.
    for (genvar b = 0; b < XLEN; b++) begin : g_keep
        assign keep_mask[b] = (b <= SAVE_A_HI) ||
                              ((b >= SAVE_B_LO) && (b <= SAVE_B_HI)) ||
                              (b >= SAVE_C_LO);
    end

    sysint_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .retire_i (retire_i),
        .is_sc_i  (is_sc_i),
        .rfi_i    (rfi_i),
        .act_o    (act)
    );

    sysint_msr_xform #(
        .XLEN    (XLEN),
        .LEV_W   (LEV_W),
        .IR_BIT  (IR_BIT),
        .DR_BIT  (DR_BIT),
        .FE0_BIT (FE0_BIT),
        .FE1_BIT (FE1_BIT),
        .EE_BIT  (EE_BIT),
        .RI_BIT  (RI_BIT),
        .ME_BIT  (ME_BIT),
        .HV_BIT  (HV_BIT),
        .S_BIT   (S_BIT)
    ) u_xform (
        .cur_msr_i    (cur_msr_i),
        .lev_i        (lev_i),
        .uv_en_i      (uv_en_i),
        .srr1_q_i     (srr1_o),
        .keep_mask_i  (keep_mask),
        .entry_msr_o  (entry_msr),
        .srr1_img_o   (srr1_img),
        .return_msr_o (return_msr)
    );

    // Architectural registers: all updated on one edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srr0_o <= '0;
            srr1_o <= '0;
            msr_o  <= RESET_MSR;
            nia_o  <= RESET_NIA;
        end else begin
            unique case (act)
                ACT_ENTER: begin
                    srr0_o <= cia_i + INSN_STEP;
                    srr1_o <= srr1_img;
                    msr_o  <= entry_msr;
                    nia_o  <= VECTOR;
                end
                ACT_RETURN: begin
                    msr_o <= return_msr;
                    nia_o <= srr0_o;
                end
                default: ;
            endcase
        end
    end

    // Assertions: armed one edge after reset so $past never reaches into reset.
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r2_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(retire_i && is_sc_i)) |-> (srr0_o == $past(cia_i) + INSN_STEP));

    a_r3_saved_image: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(retire_i && is_sc_i)) |-> (srr1_o == ($past(cur_msr_i) & keep_mask)));

    a_r4_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(retire_i && is_sc_i)) |-> (nia_o == VECTOR));

    a_r5_msr_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(retire_i && is_sc_i)) |->
        ($countones(msr_o) <= 3 && !msr_o[IR_BIT] && !msr_o[DR_BIT] && !msr_o[EE_BIT]
         && !msr_o[RI_BIT] && !msr_o[FE0_BIT] && !msr_o[FE1_BIT]
         && msr_o[ME_BIT] == $past(cur_msr_i[ME_BIT])));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!(retire_i && is_sc_i) && !rfi_i)) |->
        ($stable(srr0_o) && $stable(srr1_o) && $stable(msr_o) && $stable(nia_o)));

    a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(rfi_i && !(retire_i && is_sc_i))) |->
        (nia_o == $past(srr0_o) && $stable(srr0_o) && $stable(srr1_o)));

endmodule

// File: tb/sysint_entry_test.sv
module sysint_entry_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] KEEP = 64'hFFFF_03E1_FFFF_FFFF;
    localparam logic [63:0] VEC  = 64'h0000_0000_0000_0C00;
    localparam int B_IR = 5, B_DR = 4, B_FE0 = 11, B_FE1 = 8, B_EE = 15, B_RI = 1;
    localparam int B_ME = 12, B_HV = 60, B_S = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire = 1'b0;
    logic        is_sc = 1'b0;
    logic [6:0]  lev = '0;
    logic        uv_en = 1'b0;
    logic        rfi = 1'b0;
    logic [63:0] cia = '0;
    logic [63:0] cur_msr = '0;
    logic [63:0] srr0, srr1, msr, nia;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysint_entry uut (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .is_sc_i(is_sc),
        .lev_i(lev), .uv_en_i(uv_en), .rfi_i(rfi), .cia_i(cia),
        .cur_msr_i(cur_msr), .srr0_o(srr0), .srr1_o(srr1), .msr_o(msr), .nia_o(nia)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_entry_msr(input logic [63:0] m,
                                                  input logic [6:0] l, input logic u);
        logic [63:0] r = '0;
        r[B_ME] = m[B_ME];
        r[B_HV] = (l == 7'd0) ? m[B_HV] : 1'b1;
        r[B_S]  = (u && l == 7'd2) ? 1'b1 : m[B_S];
        return r;
    endfunction

    // Entry stimulus: one rising edge, checked at the next falling edge.
    task automatic do_entry(input logic [63:0] a, input logic [63:0] m,
                            input logic [6:0] l, input logic u);
        logic [63:0] em;
        @(negedge clk);
        cia = a; cur_msr = m; lev = l; uv_en = u; retire = 1'b1; is_sc = 1'b1;
        @(negedge clk);
        retire = 1'b0; is_sc = 1'b0;
        em = exp_entry_msr(m, l, u);
        chk("R2 srr0", srr0, a + 64'd4);
        chk("R3 srr1", srr1, m & KEEP);
        chk("R4 nia", nia, VEC);
        chk("R5 msr", msr, em);
        chk("R5 IR", 64'(msr[B_IR]), 64'd0);
        chk("R5 DR", 64'(msr[B_DR]), 64'd0);
        chk("R5 FE0", 64'(msr[B_FE0]), 64'd0);
        chk("R5 FE1", 64'(msr[B_FE1]), 64'd0);
        chk("R5 EE", 64'(msr[B_EE]), 64'd0);
        chk("R5 RI", 64'(msr[B_RI]), 64'd0);
        chk("R5 ME", 64'(msr[B_ME]), 64'(m[B_ME]));
        chk("R6 HV", 64'(msr[B_HV]), (l == 7'd0) ? 64'(m[B_HV]) : 64'd1);
        chk("R7 S", 64'(msr[B_S]), (u && l == 7'd2) ? 64'd1 : 64'(m[B_S]));
    endtask

    task automatic do_return(input logic [63:0] m);
        logic [63:0] s0, s1;
        s0 = srr0; s1 = srr1;
        @(negedge clk);
        cur_msr = m; rfi = 1'b1;
        @(negedge clk);
        rfi = 1'b0;
        chk("R9 nia", nia, s0);
        chk("R9 msr", msr, (m & ~KEEP) | (s1 & KEEP));
        chk("R9 srr0 kept", srr0, s0);
        chk("R9 srr1 kept", srr1, s1);
    endtask

    task automatic do_hold(input logic r, input logic s, input string tag);
        logic [63:0] s0, s1, ms, ni;
        s0 = srr0; s1 = srr1; ms = msr; ni = nia;
        @(negedge clk);
        retire = r; is_sc = s; rfi = 1'b0;
        cia = 64'hDEAD_BEEF_0000_0010; cur_msr = 64'hFFFF_FFFF_FFFF_FFFF;
        lev = 7'd2; uv_en = 1'b1;
        @(negedge clk);
        retire = 1'b0; is_sc = 1'b0;
        chk({tag, " srr0"}, srr0, s0);
        chk({tag, " srr1"}, srr1, s1);
        chk({tag, " msr"}, msr, ms);
        chk({tag, " nia"}, nia, ni);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] pats [6];
        pats[0] = 64'h0;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'hAAAA_AAAA_AAAA_AAAA;
        pats[3] = 64'h5555_5555_5555_5555;
        pats[4] = 64'h1000_0000_0040_1000;
        pats[5] = 64'h0123_4567_89AB_CDEF;

        #(CLK_PERIOD * 2 + 1);
        chk("R1 srr0", srr0, 64'd0);
        chk("R1 srr1", srr1, 64'd0);
        chk("R1 msr", msr, 64'd0);
        chk("R1 nia", nia, 64'h100);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: strobes that must not act, straight after reset.
        do_hold(1'b1, 1'b0, "R8 retire-only");
        do_hold(1'b0, 1'b1, "R8 sc-only");

        // Sweep MSR patterns, LEV values and the enable; return after each.
        for (int p = 0; p < 6; p++) begin
            for (int l = 0; l < 4; l++) begin
                for (int u = 0; u < 2; u++) begin
                    do_entry(64'h0000_0000_0001_0000 + 64'(p * 256 + l * 16 + u * 4),
                             pats[p], 7'(l), u[0]);
                    do_return(~pats[p]);
                end
            end
        end

        // LEV values above 3 and the address wrap.
        do_entry(64'hFFFF_FFFF_FFFF_FFFC, 64'h1000_0000_0040_1000, 7'd127, 1'b1);
        do_hold(1'b1, 1'b0, "R8 after entry");
        do_hold(1'b0, 1'b1, "R8 idle strobe");
        do_return(64'h0);

        // R10: entry and return on the same edge.
        @(negedge clk);
        cia = 64'h0000_0000_0002_0000; cur_msr = 64'hFFFF_FFFF_FFFF_FFFF;
        lev = 7'd0; uv_en = 1'b0; retire = 1'b1; is_sc = 1'b1; rfi = 1'b1;
        @(negedge clk);
        retire = 1'b0; is_sc = 1'b0; rfi = 1'b0;
        chk("R10 nia", nia, VEC);
        chk("R10 srr0", srr0, 64'h0000_0000_0002_0004);
        chk("R10 msr", msr, exp_entry_msr(64'hFFFF_FFFF_FFFF_FFFF, 7'd0, 1'b0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule